// File: doc/BRIEF.md
# Trace Register Access Trap Decoder

This block decides what happens when software running on a processor element reads or writes a trace-unit control register through the system-register path. It looks at the current privilege level, the access direction and the trap controls of every level. It also looks at the state of a fine-grained trap facility, a secure-debug undefined condition and the terms of a debug-halt request. From these it gives exactly one outcome: the access is undefined, it traps to level 1, 2 or 3, it causes a debug halt, or it is allowed.

The decoder is purely combinational. The outcome is a one-hot vector. When the outcome is a trap, a separate output carries the syndrome exception class that the exception-entry logic records. Each privilege level has its own fixed priority chain, and the first condition that matches in that chain wins. Register storage and exception entry are left to neighbouring logic.

Top module: `trace_acc_trap_dec`

## Requirements
- R1: Any access made at privilege level 0 (`cur_lvl` = 0) gives the outcome undefined (`outcome` = 6'b000001), whatever the other inputs are.
- R2: At level 1 or 2, if level 3 exists, the secure-debug priority flag is set and the level-3 trap bit is set, the outcome is undefined. This takes precedence over every other check at those levels.
- R3: At level 1, when R2 does not apply, a set level-1 trap bit gives a trap to level 1 (`outcome` = 6'b000010).
- R4: At level 1, when nothing earlier applies, the outcome is a trap to level 2 (`outcome` = 6'b000100) if level 2 is enabled and the level-2 trap bit is set. With level 2 disabled, the level-2 trap bit has no effect at level 1.
- R5: At level 1, when nothing earlier applies, the outcome is a trap to level 2 if all of these hold: level 2 is enabled, the fine-grained facility exists, level 3 is absent or its fine-grained enable is set, and the fine-grained trap bit for the access direction is set. A read uses `fg_rd_trap` and a write (`is_write` = 1) uses `fg_wr_trap`. The bit for the other direction has no effect.
- R6: At level 1 or 2, when nothing earlier applies and level 3 exists with its trap bit set, the outcome is undefined if the secure-debug undefined condition holds. Otherwise it is a trap to level 3 (`outcome` = 6'b001000).
- R7: When no trap or undefined check applies, the outcome is a debug halt (`outcome` = 6'b010000) if all of these hold: the external trace facility exists, the OS lock is clear, halting is allowed and the debug trap bit is set. At levels 2 and 3 the halt also requires that level 1 does not use the 32-bit execution state. At level 1 that flag is ignored.
- R8: At level 2, a set level-2 trap bit gives a trap to level 2 after R2, whether or not level 2 is enabled. The level-1 trap bit and the fine-grained bits have no effect at level 2.
- R9: At level 3, a set level-3 trap bit always gives a trap to level 3. The secure-debug inputs and the level-1 and level-2 trap bits have no effect at level 3.
- R10: When no check in the chain of the current level matches, the outcome is allowed (`outcome` = 6'b100000).
- R11: `outcome` always has exactly one bit set. `syn_class` is 6'h18 for the three trap outcomes and 0 for all other outcomes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| is_write | input | 1 | 1 for a register write, 0 for a read |
| lvl3_exists | input | 1 | Privilege level 3 is implemented |
| lvl2_enabled | input | 1 | Privilege level 2 is enabled for the current state |
| trap_l1 | input | 1 | Level-1 trace access trap control bit |
| trap_l2 | input | 1 | Level-2 trace access trap control bit |
| trap_l3 | input | 1 | Level-3 trace access trap control bit |
| fg_present | input | 1 | Fine-grained trap facility is implemented |
| fg_l3_en | input | 1 | Level-3 enable of the fine-grained traps |
| fg_rd_trap | input | 1 | Fine-grained trap bit for reads |
| fg_wr_trap | input | 1 | Fine-grained trap bit for writes |
| sdbg_undef | input | 1 | Secure-debug undefined condition |
| sdbg_undef_prio | input | 1 | Secure-debug undefined takes priority |
| xtrc_present | input | 1 | External trace facility is implemented |
| os_locked | input | 1 | OS lock is set |
| halt_permit | input | 1 | Debug halting is currently allowed |
| dbg_trap | input | 1 | Debug trap control bit for trace accesses |
| l1_is_32bit | input | 1 | Level 1 uses the 32-bit execution state |
| outcome | output | 6 | One-hot result: bit0 undefined, bit1 trap L1, bit2 trap L2, bit3 trap L3, bit4 halt, bit5 allowed |
| syn_class | output | 6 | Syndrome exception class for trap outcomes, 0 otherwise |

## Verification
The bench goes after the overlaps in each chain, where more than one condition matches at the same time. Examples are the priority-undefined check alongside the level-1 trap bit, and the level-2 trap bit at level 1 with level 2 disabled, which a design without the enable would wrongly trap. It also drives the fine-grained bit of the wrong direction and the case where level 3 exists with its fine-grained enable clear. A decoder that swapped the read and write bits or dropped the level-3 gate would trap those accesses to level 2. The 32-bit level-1 flag is tested against the halt at each level: a design that applied it at level 1, or left it out at level 2 or 3, would halt or allow the wrong accesses. Random vectors across all inputs are compared against a behavioural model of the priority chains. They catch any order mistake the directed cases miss.

// File: rtl/tdec_pkg.sv
package tdec_pkg;

  localparam int unsigned RES_W   = 6;
  localparam int unsigned RES_UND = 0;
  localparam int unsigned RES_TL1 = 1;
  localparam int unsigned RES_TL2 = 2;
  localparam int unsigned RES_TL3 = 3;
  localparam int unsigned RES_HLT = 4;
  localparam int unsigned RES_OK  = 5;

  localparam int unsigned SYN_W    = 6;
  localparam logic [SYN_W-1:0] SYN_TRAP = 6'h18;

  typedef logic [RES_W-1:0] res_t;

  typedef struct packed {
    logic is_write;
    logic lvl3_exists;
    logic lvl2_enabled;
    logic trap_l1;
    logic trap_l2;
    logic trap_l3;
    logic fg_present;
    logic fg_l3_en;
    logic fg_rd_trap;
    logic fg_wr_trap;
    logic sdbg_undef;
    logic sdbg_undef_prio;
    logic xtrc_present;
    logic os_locked;
    logic halt_permit;
    logic dbg_trap;
    logic l1_is_32bit;
  } tdec_ctl_t;

  function automatic res_t res_onehot(input int unsigned idx);
    res_t r;
    r = '0;
    r[idx] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/tdec_halt_eval.sv
module tdec_halt_eval
  import tdec_pkg::*;
#(
  parameter bit NEED_64BIT_L1 = 1'b1
) (
  input  tdec_ctl_t ctl,
  output logic      halt_hit
);

  logic base_hit;

  always_comb begin
    base_hit = ctl.xtrc_present & ~ctl.os_locked & ctl.halt_permit & ctl.dbg_trap;
  end

  generate
    if (NEED_64BIT_L1) begin : g_strict
      always_comb halt_hit = base_hit & ~ctl.l1_is_32bit;
    end else begin : g_relaxed
      always_comb halt_hit = base_hit;
    end
  endgenerate

endmodule

// File: rtl/tdec_level_chain.sv
module tdec_level_chain
  import tdec_pkg::*;
#(
  parameter int unsigned LEVEL = 1
) (
  input  tdec_ctl_t ctl,
  input  logic      halt_hit,
  output res_t      res
);

  logic prio_undef;
  logic l3_hit;
  logic fg_dir_bit;
  logic fg_hit;
  res_t l3_res;

  always_comb begin
    prio_undef = ctl.lvl3_exists & ctl.sdbg_undef_prio & ctl.trap_l3;
    l3_hit     = ctl.lvl3_exists & ctl.trap_l3;
    fg_dir_bit = ctl.is_write ? ctl.fg_wr_trap : ctl.fg_rd_trap;
    fg_hit     = ctl.lvl2_enabled & ctl.fg_present
               & (~ctl.lvl3_exists | ctl.fg_l3_en) & fg_dir_bit;
    l3_res     = ctl.sdbg_undef ? res_onehot(RES_UND) : res_onehot(RES_TL3);
  end

  generate
    if (LEVEL == 1) begin : g_lvl1
      always_comb begin
        if (prio_undef)                          res = res_onehot(RES_UND);
        else if (ctl.trap_l1)                    res = res_onehot(RES_TL1);
        else if (ctl.lvl2_enabled & ctl.trap_l2) res = res_onehot(RES_TL2);
        else if (fg_hit)                         res = res_onehot(RES_TL2);
        else if (l3_hit)                         res = l3_res;
        else if (halt_hit)                       res = res_onehot(RES_HLT);
        else                                     res = res_onehot(RES_OK);
      end
    end else if (LEVEL == 2) begin : g_lvl2
      always_comb begin
        if (prio_undef)        res = res_onehot(RES_UND);
        else if (ctl.trap_l2)  res = res_onehot(RES_TL2);
        else if (l3_hit)       res = l3_res;
        else if (halt_hit)     res = res_onehot(RES_HLT);
        else                   res = res_onehot(RES_OK);
      end
    end else begin : g_lvl3
      always_comb begin
        if (ctl.trap_l3)       res = res_onehot(RES_TL3);
        else if (halt_hit)     res = res_onehot(RES_HLT);
        else                   res = res_onehot(RES_OK);
      end
    end
  endgenerate

endmodule

// File: rtl/tdec_syndrome.sv
module tdec_syndrome
  import tdec_pkg::*;
(
  input  res_t             res,
  output logic [SYN_W-1:0] syn
);

  logic is_trap;

  always_comb begin
    is_trap = res[RES_TL1] | res[RES_TL2] | res[RES_TL3];
    syn     = is_trap ? SYN_TRAP : '0;
  end

endmodule

// File: rtl/trace_acc_trap_dec.sv
module trace_acc_trap_dec
  import tdec_pkg::*;
(
  input  logic [1:0]       cur_lvl,
  input  logic             is_write,
  input  logic             lvl3_exists,
  input  logic             lvl2_enabled,
  input  logic             trap_l1,
  input  logic             trap_l2,
  input  logic             trap_l3,
  input  logic             fg_present,
  input  logic             fg_l3_en,
  input  logic             fg_rd_trap,
  input  logic             fg_wr_trap,
  input  logic             sdbg_undef,
  input  logic             sdbg_undef_prio,
  input  logic             xtrc_present,
  input  logic             os_locked,
  input  logic             halt_permit,
  input  logic             dbg_trap,
  input  logic             l1_is_32bit,
  output logic [RES_W-1:0] outcome,
  output logic [SYN_W-1:0] syn_class
);

  localparam int unsigned NUM_LVL = 4;

  tdec_ctl_t ctl;
  logic      halt_relaxed;
  logic      halt_strict;
  res_t      lvl_res [NUM_LVL];
  res_t      sel_res;

  always_comb begin
    ctl.is_write        = is_write;
    ctl.lvl3_exists     = lvl3_exists;
    ctl.lvl2_enabled    = lvl2_enabled;
    ctl.trap_l1         = trap_l1;
    ctl.trap_l2         = trap_l2;
    ctl.trap_l3         = trap_l3;
    ctl.fg_present      = fg_present;
    ctl.fg_l3_en        = fg_l3_en;
    ctl.fg_rd_trap      = fg_rd_trap;
    ctl.fg_wr_trap      = fg_wr_trap;
    ctl.sdbg_undef      = sdbg_undef;
    ctl.sdbg_undef_prio = sdbg_undef_prio;
    ctl.xtrc_present    = xtrc_present;
    ctl.os_locked       = os_locked;
    ctl.halt_permit     = halt_permit;
    ctl.dbg_trap        = dbg_trap;
    ctl.l1_is_32bit     = l1_is_32bit;
  end

  tdec_halt_eval #(.NEED_64BIT_L1(1'b0)) u_halt_relaxed (
    .ctl      (ctl),
    .halt_hit (halt_relaxed)
  );

  tdec_halt_eval #(.NEED_64BIT_L1(1'b1)) u_halt_strict (
    .ctl      (ctl),
    .halt_hit (halt_strict)
  );

  always_comb lvl_res[0] = res_onehot(RES_UND);

  generate
    for (genvar g = 1; g < NUM_LVL; g++) begin : g_chain
      tdec_level_chain #(.LEVEL(g)) u_chain (
        .ctl      (ctl),
        .halt_hit ((g == 1) ? halt_relaxed : halt_strict),
        .res      (lvl_res[g])
      );
    end
  endgenerate

  always_comb begin
    sel_res = lvl_res[cur_lvl];
  end

  tdec_syndrome u_syn (
    .res (sel_res),
    .syn (syn_class)
  );

  always_comb outcome = sel_res;

endmodule

// File: rtl/trace_acc_trap_dec_chk.sv
module trace_acc_trap_dec_chk
  import tdec_pkg::*;
(
  input logic [1:0]       cur_lvl,
  input logic             lvl3_exists,
  input logic             trap_l3,
  input logic             sdbg_undef_prio,
  input logic             l1_is_32bit,
  input logic [RES_W-1:0] outcome,
  input logic [SYN_W-1:0] syn_class
);

  logic any_trap;

  always_comb begin
    any_trap = outcome[RES_TL1] | outcome[RES_TL2] | outcome[RES_TL3];
    p_onehot_r11: assert ($countones(outcome) == 1)
      else $error("outcome not one-hot: %b", outcome);
    p_syn_trap_r11: assert (!any_trap || syn_class == SYN_TRAP)
      else $error("trap without class 0x18");
    p_syn_zero_r11: assert (any_trap || syn_class == '0)
      else $error("non-trap with nonzero class");
    p_lvl0_undef_r1: assert (cur_lvl != 2'd0 || outcome == res_onehot(RES_UND))
      else $error("level 0 not undefined");
    p_prio_undef_r2: assert (!((cur_lvl == 2'd1 || cur_lvl == 2'd2) && lvl3_exists
                               && sdbg_undef_prio && trap_l3)
                             || outcome == res_onehot(RES_UND))
      else $error("priority undefined missed");
    p_l3_trap_r9: assert (!(cur_lvl == 2'd3 && trap_l3) || outcome == res_onehot(RES_TL3))
      else $error("level 3 trap missed");
    p_halt_64_r7: assert (!(cur_lvl >= 2'd2 && outcome[RES_HLT]) || !l1_is_32bit)
      else $error("halt with 32-bit level 1");
  end

endmodule

bind trace_acc_trap_dec trace_acc_trap_dec_chk u_chk (
  .cur_lvl         (cur_lvl),
  .lvl3_exists     (lvl3_exists),
  .trap_l3         (trap_l3),
  .sdbg_undef_prio (sdbg_undef_prio),
  .l1_is_32bit     (l1_is_32bit),
  .outcome         (outcome),
  .syn_class       (syn_class)
);

// File: tb/trace_acc_trap_dec_test.sv
module trace_acc_trap_dec_test;

  localparam int B_WR   = 1 << 2;
  localparam int B_H3   = 1 << 3;
  localparam int B_L2E  = 1 << 4;
  localparam int B_T1   = 1 << 5;
  localparam int B_T2   = 1 << 6;
  localparam int B_T3   = 1 << 7;
  localparam int B_FGP  = 1 << 8;
  localparam int B_FGE  = 1 << 9;
  localparam int B_FGR  = 1 << 10;
  localparam int B_FGW  = 1 << 11;
  localparam int B_SDU  = 1 << 12;
  localparam int B_SDP  = 1 << 13;
  localparam int B_XT   = 1 << 14;
  localparam int B_OSL  = 1 << 15;
  localparam int B_HP   = 1 << 16;
  localparam int B_DBG  = 1 << 17;
  localparam int B_A32  = 1 << 18;
  localparam int B_HALT = B_XT | B_HP | B_DBG;

  logic clk;
  logic rst_n;
  logic [18:0] v;
  logic [5:0] outcome;
  logic [5:0] syn_class;
  int n_chk;
  int n_fail;
  bit done;

  trace_acc_trap_dec uut (
    .cur_lvl(v[1:0]), .is_write(v[2]), .lvl3_exists(v[3]), .lvl2_enabled(v[4]),
    .trap_l1(v[5]), .trap_l2(v[6]), .trap_l3(v[7]), .fg_present(v[8]),
    .fg_l3_en(v[9]), .fg_rd_trap(v[10]), .fg_wr_trap(v[11]), .sdbg_undef(v[12]),
    .sdbg_undef_prio(v[13]), .xtrc_present(v[14]), .os_locked(v[15]),
    .halt_permit(v[16]), .dbg_trap(v[17]), .l1_is_32bit(v[18]),
    .outcome(outcome), .syn_class(syn_class)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference: outcome index 0 undef,1 trap L1,2 trap L2,3 trap L3,4 halt,5 allow
  function automatic int model(input logic [18:0] s, output string tag);
    int lvl;
    bit halt;
    bit fgd;
    lvl  = int'(s[1:0]);
    halt = s[14] && !s[15] && s[16] && s[17];
    fgd  = s[2] ? s[11] : s[10];
    if (lvl == 0) begin tag = "R1"; return 0; end
    if (lvl == 3) begin
      if (s[7]) begin tag = "R9"; return 3; end
      if (halt && !s[18]) begin tag = "R7"; return 4; end
      tag = "R10"; return 5;
    end
    if (s[3] && s[13] && s[7]) begin tag = "R2"; return 0; end
    if (lvl == 1) begin
      if (s[5]) begin tag = "R3"; return 1; end
      if (s[4] && s[6]) begin tag = "R4"; return 2; end
      if (s[4] && s[8] && (!s[3] || s[9]) && fgd) begin tag = "R5"; return 2; end
    end else begin
      if (s[6]) begin tag = "R8"; return 2; end
    end
    if (s[3] && s[7]) begin tag = "R6"; return s[12] ? 0 : 3; end
    if (halt && (lvl == 1 || !s[18])) begin tag = "R7"; return 4; end
    tag = "R10"; return 5;
  endfunction

  task automatic apply_check(input int stim, input string req);
    string mtag;
    int idx;
    logic [5:0] exp_o;
    logic [5:0] exp_s;
    @(posedge clk);
    v <= stim[18:0];
    @(negedge clk);
    idx   = model(stim[18:0], mtag);
    exp_o = 6'(1 << idx);
    exp_s = (idx >= 1 && idx <= 3) ? 6'h18 : 6'h00;
    n_chk++;
    if (outcome !== exp_o || syn_class !== exp_s) begin
      n_fail++;
      $display("FAIL %s/%s stim=%h outcome=%b exp=%b syn=%h exp=%h (R11)",
               req, mtag, stim, outcome, exp_o, syn_class, exp_s);
    end
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    v = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (outcome !== 6'b000001) begin
      n_fail++;
      $display("FAIL R1 reset outcome=%b exp=000001", outcome);
    end
    apply_check(32'h7FFFC, "R1");
    apply_check(1 | B_H3 | B_SDP | B_T3 | B_T1, "R2");
    apply_check(2 | B_H3 | B_SDP | B_T3 | B_T2, "R2");
    apply_check(1 | B_T1 | B_T2 | B_L2E, "R3");
    apply_check(1 | B_T2 | B_L2E | B_FGP | B_FGR, "R4");
    apply_check(1 | B_T2, "R4");
    apply_check(1 | B_L2E | B_FGP | B_FGR, "R5");
    apply_check(1 | B_WR | B_L2E | B_FGP | B_FGR, "R5");
    apply_check(1 | B_WR | B_L2E | B_FGP | B_FGW, "R5");
    apply_check(1 | B_L2E | B_FGP | B_FGR | B_H3, "R5");
    apply_check(1 | B_L2E | B_FGP | B_FGR | B_H3 | B_FGE, "R5");
    apply_check(1 | B_H3 | B_T3 | B_SDU, "R6");
    apply_check(2 | B_H3 | B_T3, "R6");
    apply_check(1 | B_T3, "R6");
    apply_check(1 | B_HALT, "R7");
    apply_check(1 | B_HALT | B_A32, "R7");
    apply_check(1 | B_HALT | B_OSL, "R7");
    apply_check(2 | B_HALT | B_A32, "R7");
    apply_check(2 | B_HALT, "R7");
    apply_check(3 | B_HALT | B_A32, "R7");
    apply_check(2 | B_T2, "R8");
    apply_check(2 | B_T1 | B_L2E | B_FGP | B_FGR | B_FGW, "R8");
    apply_check(3 | B_T3 | B_H3 | B_SDP | B_SDU, "R9");
    apply_check(3 | B_T1 | B_T2 | B_L2E | B_SDP | B_H3, "R9");
    apply_check(3 | B_HALT, "R9");
    apply_check(1, "R10");
    apply_check(2 | B_FGP | B_FGR, "R10");
    for (int i = 0; i < 6000; i++) begin
      apply_check(int'($urandom() & 32'h7FFFF), "R11");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule